// File: doc/BRIEF.md
# Arithmetic and Logic Unit with Flag Register

This block combines two operands of one data word in a single cycle and keeps an eight-bit flag register next to the datapath. The result is combinational. When an operation is issued, the flag register loads the flags that operation produces at the next clock edge. The operation set has four arithmetic groups: addition and subtraction, each with and without the stored carry. It also has bitwise AND, OR and XOR, one's complement, two's-complement negation, increment, decrement, and logical and arithmetic right shifts. Two bit-move operations copy one operand bit into the storage bit, or copy the storage bit into one bit of the result.

The flag register holds eight bits. Six are condition flags: carry, zero, negative, signed overflow, sign, and the nibble carry used for decimal arithmetic. The other two are control bits: the global interrupt enable and the bit-move storage bit. The surrounding core can overwrite the whole register in one cycle. It can also set or clear either control bit on its own. Because the flags follow every operation, a branch can test them directly without a separate compare.

Top module: `alu_flag_unit`

## Requirements
- R1: After reset the flag register reads 0x00. Its bit positions are: 7 interrupt enable, 6 storage bit, 5 nibble carry H, 4 sign S, 3 overflow V, 2 negative N, 1 zero Z, 0 carry C.
- R2: Add and add-with-carry give a+b(+C). C is the carry out of bit 7, H is the carry out of bit 3, V is two's-complement overflow, N is result bit 7, and Z is set when the result is zero.
- R3: Subtract, subtract-with-carry and negate give a-b(-C) and 0-a. C is the borrow out of bit 7, H is the borrow into bit 4, and V, N and Z follow the rules in R2.
- R4: Subtract-with-carry sets Z only if the result is zero and Z was already set, so that a multi-byte compare chains correctly.
- R5: After every flag-writing operation, S equals N xor V.
- R6: AND, OR and XOR clear V and leave C and H unchanged. Complement also clears V, forces C to 1 and leaves H unchanged.
- R7: Increment and decrement leave C and H unchanged. V is set exactly when increment gives 0x80 or decrement gives 0x7F.
- R8: Logical and arithmetic right shifts load C from operand bit 0 and set V to N xor C. The logical shift inserts 0 at the top and the arithmetic shift repeats bit 7. H is unchanged.
- R9: The bit-store operation (code 13) copies a bit of operand a into the storage bit and returns a unchanged. The bit-load operation (code 14) returns a with one bit replaced by the storage bit. In both, b[2:0] selects the bit, and no condition flag changes.
- R10: With the issue strobe low, or with the spare code 15, the flag register keeps its value. Code 15 returns operand a.
- R11: A full-register write wins over the flags of an operation issued in the same cycle.
- R12: The set and clear strobes for the interrupt enable and the storage bit act after any full write and after any operation. Set wins over clear.
- R13: The result output depends only on the current operands, operation code and flag register, with no clock delay. The codes are: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-carry, 4 AND, 5 OR, 6 XOR, 7 complement, 8 negate, 9 increment, 10 decrement, 11 logical shift right, 12 arithmetic shift right.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Issue strobe; the flags update at the next edge |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First operand (destination register value) |
| b_i | input | 8 | Second operand, immediate, or bit index |
| res_o | output | 8 | Combinational result |
| sreg_o | output | 8 | Flag register |
| sreg_wr_i | input | 1 | Full flag register write strobe |
| sreg_wdata_i | input | 8 | Value for the full write |
| ien_set_i | input | 1 | Set interrupt enable |
| ien_clr_i | input | 1 | Clear interrupt enable |
| tbit_set_i | input | 1 | Set storage bit |
| tbit_clr_i | input | 1 | Clear storage bit |

## Verification
The hardest cases to reach are the ones where the outcome depends on flags left behind by earlier operations. Examples are the chained zero of subtract-with-carry and the carry and nibble-carry that logical and increment operations must keep. Each table vector therefore first loads a chosen flag byte through the full-write port and then issues its operation, so that a preserved flag is told apart from a freshly computed one. Directed tests then collide a full write, the control-bit strobes and an issued operation in the same cycle to expose the merge order.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_COM = 4'd7,
        OP_NEG = 4'd8,
        OP_INC = 4'd9,
        OP_DEC = 4'd10,
        OP_LSR = 4'd11,
        OP_ASR = 4'd12,
        OP_BST = 4'd13,
        OP_BLD = 4'd14,
        OP_NOP = 4'd15
    } alu_op_e;

    // packed MSB first: i is bit 7, c is bit 0
    typedef struct packed {
        logic i;
        logic t;
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } sreg_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W  = 8,
    parameter int HB = W / 2
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         half,
    output logic         ovf
);
    logic [W-1:0] bx;
    logic         cx;
    logic [W:0]   full;
    logic [HB:0]  low;

    // subtraction as a + ~b + ~borrow_in
    assign bx    = sub ? ~b : b;
    assign cx    = sub ? ~cin : cin;
    assign full  = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cx};
    assign low   = {1'b0, a[HB-1:0]} + {1'b0, bx[HB-1:0]} + {{HB{1'b0}}, cx};
    assign sum   = full[W-1:0];
    assign carry = full[W] ^ sub;
    assign half  = low[HB] ^ sub;
    assign ovf   = (a[W-1] == bx[W-1]) && (full[W-1] != a[W-1]);
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_flag_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    always_comb begin
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_COM:  res = ~a;
            OP_LSR:  res = {1'b0, a[W-1:1]};
            OP_ASR:  res = {a[W-1], a[W-1:1]};
            default: res = a;
        endcase
    end
endmodule

// File: rtl/alu_bitmove.sv
module alu_bitmove #(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  a,
    input  logic [IW-1:0] idx,
    input  logic          t_in,
    output logic [W-1:0]  ld_res,
    output logic          st_bit
);
    generate
        for (genvar g = 0; g < W; g++) begin : g_bit
            assign ld_res[g] = (idx == IW'(g)) ? t_in : a[g];
        end
    endgenerate

    assign st_bit = a[idx];
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_flag_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid_i,
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o,
    output logic [7:0]   sreg_o,
    input  logic         sreg_wr_i,
    input  logic [7:0]   sreg_wdata_i,
    input  logic         ien_set_i,
    input  logic         ien_clr_i,
    input  logic         tbit_set_i,
    input  logic         tbit_clr_i
);
    localparam int HB = W / 2;
    localparam int IW = $clog2(W);

    typedef struct packed {
        sreg_t sreg;
    } state_t;

    state_t       st_d, st_q;
    alu_op_e      op;
    logic [W-1:0] add_a, add_b, add_sum;
    logic         add_cin, add_sub, add_c, add_h, add_v;
    logic [W-1:0] lg_res, ld_res;
    logic         st_bit;
    logic         is_arith;
    logic [W-1:0] res;

    assign op = alu_op_e'(op_i);

    // adder operand selection
    always_comb begin
        add_a    = a_i;
        add_b    = b_i;
        add_cin  = 1'b0;
        add_sub  = 1'b0;
        is_arith = 1'b1;
        case (op)
            OP_ADD: ;
            OP_ADC: add_cin = st_q.sreg.c;
            OP_SUB: add_sub = 1'b1;
            OP_SBC: begin add_sub = 1'b1; add_cin = st_q.sreg.c; end
            OP_NEG: begin add_a = '0; add_b = a_i; add_sub = 1'b1; end
            OP_INC: add_b = W'(1);
            OP_DEC: begin add_b = W'(1); add_sub = 1'b1; end
            default: is_arith = 1'b0;
        endcase
    end

    alu_addsub #(.W(W), .HB(HB)) i_addsub (
        .a(add_a), .b(add_b), .cin(add_cin), .sub(add_sub),
        .sum(add_sum), .carry(add_c), .half(add_h), .ovf(add_v)
    );

    alu_bitwise #(.W(W)) i_bitwise (
        .op(op), .a(a_i), .b(b_i), .res(lg_res)
    );

    alu_bitmove #(.W(W), .IW(IW)) i_bitmove (
        .a(a_i), .idx(b_i[IW-1:0]), .t_in(st_q.sreg.t),
        .ld_res(ld_res), .st_bit(st_bit)
    );

    // result selection and next flag state
    always_comb begin
        sreg_t fl;
        logic  flag_op;
        logic  zero;

        if (is_arith)          res = add_sum;
        else if (op == OP_BLD) res = ld_res;
        else                   res = lg_res;

        zero    = (res == '0);
        flag_op = !(op == OP_BST || op == OP_BLD || op == OP_NOP);
        fl      = st_q.sreg;

        if (op_valid_i) begin
            case (op)
                OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
                    fl.c = add_c;
                    fl.h = add_h;
                    fl.v = add_v;
                end
                OP_AND, OP_OR, OP_XOR: fl.v = 1'b0;
                OP_COM: begin
                    fl.v = 1'b0;
                    fl.c = 1'b1;
                end
                OP_INC, OP_DEC: fl.v = add_v;
                OP_LSR, OP_ASR: begin
                    fl.c = a_i[0];
                    fl.v = res[W-1] ^ a_i[0];
                end
                OP_BST: fl.t = st_bit;
                default: ;
            endcase
            if (flag_op) begin
                fl.n = res[W-1];
                fl.z = (op == OP_SBC) ? (zero && st_q.sreg.z) : zero;
                fl.s = fl.n ^ fl.v;
            end
        end

        if (sreg_wr_i)  fl   = sreg_t'(sreg_wdata_i);
        if (ien_clr_i)  fl.i = 1'b0;
        if (ien_set_i)  fl.i = 1'b1;
        if (tbit_clr_i) fl.t = 1'b0;
        if (tbit_set_i) fl.t = 1'b1;

        st_d.sreg = fl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_o  = res;
    assign sreg_o = st_q.sreg;
endmodule

// File: rtl/alu_flag_chk.sv
module alu_flag_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid_i,
    input logic [3:0] op_i,
    input logic [7:0] sreg_o,
    input logic       sreg_wr_i,
    input logic [7:0] sreg_wdata_i,
    input logic       ien_set_i,
    input logic       ien_clr_i,
    input logic       tbit_set_i,
    input logic       tbit_clr_i
);
    logic ctl_any;
    logic flag_issue;
    logic logic_issue;

    assign ctl_any     = ien_set_i | ien_clr_i | tbit_set_i | tbit_clr_i;
    assign flag_issue  = op_valid_i && (op_i < 4'd13) && !sreg_wr_i;
    assign logic_issue = op_valid_i && (op_i >= 4'd4) && (op_i <= 4'd6)
                         && !sreg_wr_i && !ctl_any;

    assert_sign_rule_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_issue |=> (sreg_o[4] == (sreg_o[3] ^ sreg_o[2])));

    assert_logic_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        logic_issue |=> (!sreg_o[3] && sreg_o[0] == $past(sreg_o[0])
                         && sreg_o[5] == $past(sreg_o[5])));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid_i && !sreg_wr_i && !ctl_any) |=> $stable(sreg_o));

    assert_full_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sreg_wr_i && !ctl_any) |=> (sreg_o == $past(sreg_wdata_i)));

    assert_ien_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ien_set_i |=> sreg_o[7]);

    assert_ien_clr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_clr_i && !ien_set_i) |=> !sreg_o[7]);

    assert_tbit_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tbit_set_i |=> sreg_o[6]);
endmodule

bind alu_flag_unit alu_flag_chk i_alu_flag_chk (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_i(op_i),
    .sreg_o(sreg_o), .sreg_wr_i(sreg_wr_i), .sreg_wdata_i(sreg_wdata_i),
    .ien_set_i(ien_set_i), .ien_clr_i(ien_clr_i),
    .tbit_set_i(tbit_set_i), .tbit_clr_i(tbit_clr_i)
);

// File: tb/test_alu_flag_unit.sv
module test_alu_flag_unit;
    import alu_flag_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid_i = 1'b0;
    logic [3:0] op_i = 4'd0;
    logic [7:0] a_i = 8'd0, b_i = 8'd0;
    logic [7:0] res_o, sreg_o;
    logic       sreg_wr_i = 1'b0;
    logic [7:0] sreg_wdata_i = 8'd0;
    logic       ien_set_i = 1'b0, ien_clr_i = 1'b0;
    logic       tbit_set_i = 1'b0, tbit_clr_i = 1'b0;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    alu_flag_unit i_alu_flag_unit (
        .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .res_o(res_o), .sreg_o(sreg_o),
        .sreg_wr_i(sreg_wr_i), .sreg_wdata_i(sreg_wdata_i),
        .ien_set_i(ien_set_i), .ien_clr_i(ien_clr_i),
        .tbit_set_i(tbit_set_i), .tbit_clr_i(tbit_clr_i)
    );

    // {op, a, b, flags before, result, flags after}
    localparam int NV = 27;
    localparam logic [43:0] VECS [NV] = '{
        {OP_ADD, 8'h0F, 8'h01, 8'h00, 8'h10, 8'h20},
        {OP_ADD, 8'h7F, 8'h01, 8'h00, 8'h80, 8'h2C},
        {OP_ADD, 8'h80, 8'h80, 8'h00, 8'h00, 8'h1B},
        {OP_ADC, 8'hFF, 8'h00, 8'h01, 8'h00, 8'h23},
        {OP_ADD, 8'h01, 8'h01, 8'hC0, 8'h02, 8'hC0},
        {OP_SUB, 8'h10, 8'h01, 8'h00, 8'h0F, 8'h20},
        {OP_SUB, 8'h00, 8'h01, 8'h00, 8'hFF, 8'h35},
        {OP_SUB, 8'h80, 8'h01, 8'h00, 8'h7F, 8'h38},
        {OP_SBC, 8'h05, 8'h05, 8'h03, 8'hFF, 8'h35},
        {OP_SBC, 8'h05, 8'h04, 8'h01, 8'h00, 8'h00},
        {OP_SBC, 8'h05, 8'h04, 8'h03, 8'h00, 8'h02},
        {OP_NEG, 8'h80, 8'h00, 8'h00, 8'h80, 8'h0D},
        {OP_NEG, 8'h01, 8'h00, 8'h00, 8'hFF, 8'h35},
        {OP_NEG, 8'h00, 8'h00, 8'h00, 8'h00, 8'h02},
        {OP_AND, 8'hF0, 8'h0F, 8'h29, 8'h00, 8'h23},
        {OP_OR,  8'h80, 8'h01, 8'h08, 8'h81, 8'h14},
        {OP_XOR, 8'hAA, 8'hAA, 8'h00, 8'h00, 8'h02},
        {OP_COM, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h15},
        {OP_INC, 8'h7F, 8'h00, 8'h21, 8'h80, 8'h2D},
        {OP_INC, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h02},
        {OP_DEC, 8'h80, 8'h00, 8'h01, 8'h7F, 8'h19},
        {OP_LSR, 8'h01, 8'h00, 8'h20, 8'h00, 8'h3B},
        {OP_ASR, 8'h81, 8'h00, 8'h00, 8'hC0, 8'h15},
        {OP_ASR, 8'h80, 8'h00, 8'h00, 8'hC0, 8'h0C},
        {OP_BST, 8'h08, 8'h03, 8'h00, 8'h08, 8'h40},
        {OP_BLD, 8'h00, 8'h07, 8'h40, 8'h80, 8'h40},
        {OP_BLD, 8'hFF, 8'h00, 8'h00, 8'hFE, 8'h00}
    };

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:         return "R2";
            4'd2, 4'd8:         return "R3";
            4'd3:               return "R3/R4";
            4'd4, 4'd5, 4'd6, 4'd7: return "R6";
            4'd9, 4'd10:        return "R7";
            4'd11, 4'd12:       return "R8";
            default:            return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
        end
    endtask

    task automatic preload(input logic [7:0] v);
        @(negedge clk);
        sreg_wr_i = 1'b1;
        sreg_wdata_i = v;
        op_valid_i = 1'b0;
        @(negedge clk);
        sreg_wr_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        // R1: reset value
        repeat (2) @(negedge clk);
        chk("R1", "flags in reset", sreg_o, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "flags after reset", sreg_o, 8'h00);

        for (int k = 0; k < NV; k++) begin
            logic [43:0] v;
            v = VECS[k];
            preload(v[23:16]);
            op_i = v[43:40];
            a_i = v[39:32];
            b_i = v[31:24];
            op_valid_i = 1'b1;
            #1;
            chk("R13", "combinational result", res_o, v[15:8]);
            chk(req_of(v[43:40]), "result", res_o, v[15:8]);
            @(negedge clk);
            op_valid_i = 1'b0;
            chk(req_of(v[43:40]), "flags", sreg_o, v[7:0]);
            if (v[43:40] < 4'd13)
                chk("R5", "sign is n^v", {7'd0, sreg_o[4]},
                    {7'd0, sreg_o[3] ^ sreg_o[2]});
        end

        // R10: no issue strobe leaves flags alone; result still live
        preload(8'h15);
        op_i = OP_ADD; a_i = 8'h7F; b_i = 8'h01; op_valid_i = 1'b0;
        #1;
        chk("R13", "result without issue", res_o, 8'h80);
        @(negedge clk);
        chk("R10", "flags without issue", sreg_o, 8'h15);

        // R10: spare code returns a, keeps flags
        op_i = OP_NOP; a_i = 8'h5A; b_i = 8'hFF; op_valid_i = 1'b1;
        #1;
        chk("R10", "spare code result", res_o, 8'h5A);
        @(negedge clk);
        op_valid_i = 1'b0;
        chk("R10", "spare code flags", sreg_o, 8'h15);

        // R11: full write beats operation flags
        op_i = OP_ADD; a_i = 8'h7F; b_i = 8'h01; op_valid_i = 1'b1;
        sreg_wr_i = 1'b1; sreg_wdata_i = 8'h42;
        @(negedge clk);
        op_valid_i = 1'b0; sreg_wr_i = 1'b0;
        chk("R11", "write over op", sreg_o, 8'h42);

        // R12: control strobes, bit positions of R1
        preload(8'h00);
        ien_set_i = 1'b1;
        @(negedge clk);
        ien_set_i = 1'b0;
        chk("R12", "interrupt enable set", sreg_o, 8'h80);
        tbit_set_i = 1'b1;
        @(negedge clk);
        tbit_set_i = 1'b0;
        chk("R1", "storage bit position", sreg_o, 8'hC0);
        ien_clr_i = 1'b1;
        @(negedge clk);
        ien_clr_i = 1'b0;
        chk("R12", "interrupt enable clear", sreg_o, 8'h40);
        tbit_clr_i = 1'b1;
        @(negedge clk);
        tbit_clr_i = 1'b0;
        chk("R12", "storage bit clear", sreg_o, 8'h00);

        // R12: set wins over clear
        ien_set_i = 1'b1; ien_clr_i = 1'b1;
        tbit_set_i = 1'b1; tbit_clr_i = 1'b1;
        @(negedge clk);
        ien_set_i = 1'b0; ien_clr_i = 1'b0;
        tbit_set_i = 1'b0; tbit_clr_i = 1'b0;
        chk("R12", "set beats clear", sreg_o, 8'hC0);

        // R12: strobe on top of full write
        sreg_wr_i = 1'b1; sreg_wdata_i = 8'h01; ien_set_i = 1'b1;
        @(negedge clk);
        sreg_wr_i = 1'b0; ien_set_i = 1'b0;
        chk("R12", "strobe after write", sreg_o, 8'h81);

        // R12: strobe merged with operation flags
        preload(8'h00);
        op_i = OP_ADD; a_i = 8'h0F; b_i = 8'h01; op_valid_i = 1'b1;
        tbit_set_i = 1'b1;
        @(negedge clk);
        op_valid_i = 1'b0; tbit_set_i = 1'b0;
        chk("R12", "strobe with op", sreg_o, 8'h60);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule